// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block is a configuration port driven over three wires: a serial clock, a serial data line and a load strobe. All three wires are asynchronous to the system clock. Each one passes through a synchroniser, and the block then detects its rising edges. Each rising edge of the serial clock shifts the current data bit into a 20-bit frame register. Bits arrive most significant first, so the bit sent last ends up in position 0.

A rising edge of the load strobe reads the two lowest frame bits as an address. The block then copies the payload into one of three holding registers: an 18-bit function word, a 12-bit divider word or a 6-bit reference word. The divider word holds two 6-bit counts. Software programs each register once after reset. Each register keeps its value until it is addressed again. A per-register valid flag tells whether it has been written since reset.

Top module: `serial_cfg_loader`

## Requirements
- R1: On each rising edge of ser_clk, the level on ser_data is shifted into bit 0 of a 20-bit frame, and the older bits move one place up. The bit sent first therefore ends in bit 19.
- R2: A holding register never changes while no ser_load rising edge has occurred. Shifting a full frame without a load leaves all outputs unchanged.
- R3: Frame bits [1:0] = 2'b00 select the divider word, which is loaded from frame bits [13:2]. div_word[5:0] is the swallow count, div_word[11:6] is the main count, and frame bits [19:14] are ignored.
- R4: Frame bits [1:0] = 2'b10 select the reference word, which is loaded from frame bits [7:2]. Frame bits [19:8] are ignored.
- R5: When frame bit 0 = 1, the function word is loaded from frame bits [19:2], whatever the value of frame bit 1.
- R6: A load changes only the selected register. The other two keep their values.
- R7: Reset clears all three holding registers and all three valid flags to zero. A valid flag rises with the first load of its register and stays high until reset.
- R8: A ser_load edge that comes before 20 serial clocks have been shifted transfers the frame as it stands. The frame then holds the older bits moved up by the number of new bits.
- R9: A holding register takes its new value on the third rising edge of clk after ser_load rises, as seen at the ports.
- R10: When more than 20 bits are shifted before a load, only the last 20 bits take part in the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data bit, most significant first |
| ser_load | input | 1 | Load strobe; its rising edge transfers the frame |
| func_word | output | 18 | Function holding register |
| div_word | output | 12 | Divider holding register: main count [11:6], swallow count [5:0] |
| ref_word | output | 6 | Reference holding register |
| func_valid | output | 1 | Function word written since reset |
| div_valid | output | 1 | Divider word written since reset |
| ref_valid | output | 1 | Reference word written since reset |

## Verification
The bench drives frames for each of the four address codes. Codes 01 and 11 both target the function word, which separates the one-bit function decode from the two-bit divider and reference decodes. The divider and reference frames carry nonzero junk in their ignored upper bits, which shows that exactly the right field is extracted.

Further patterns cover three cases:
- A frame shifted without a load.
- A short 8-bit frame that leaves older bits in place.
- A 24-bit frame whose first four bits must fall off the top.

A load timed at a known system-clock edge pins the three-cycle latency. A behavioural model built from delay histories and a bitwise shift is compared with every output on every clock.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam int FRAME_W = 20;
  localparam int ADDR_W  = 2;
  localparam int FUNC_W  = 18;
  localparam int CNT_W   = 6;
  localparam int DIV_W   = 2 * CNT_W;
  localparam int REF_W   = CNT_W;

  typedef enum logic [1:0] {
    TGT_DIV  = 2'd0,
    TGT_FUNC = 2'd1,
    TGT_REF  = 2'd2
  } cfg_target_e;

  // Bit 0 alone picks the function word; bit 1 matters only when bit 0 is low.
  function automatic cfg_target_e decode_target(input logic [ADDR_W-1:0] addr);
    if (addr[0])      return TGT_FUNC;
    else if (addr[1]) return TGT_REF;
    else              return TGT_DIV;
  endfunction

  function automatic logic [FUNC_W-1:0] func_field(input logic [FRAME_W-1:0] frame);
    return frame[ADDR_W +: FUNC_W];
  endfunction

  function automatic logic [DIV_W-1:0] div_field(input logic [FRAME_W-1:0] frame);
    return frame[ADDR_W +: DIV_W];
  endfunction

  function automatic logic [REF_W-1:0] ref_field(input logic [FRAME_W-1:0] frame);
    return frame[ADDR_W +: REF_W];
  endfunction

endpackage

// File: rtl/cfg_in_sync.sv
module cfg_in_sync #(
  parameter int STAGES = 2,
  parameter int LANES  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] raw_in,
  output logic [LANES-1:0] level_out,
  output logic [LANES-1:0] rise_out
);

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [STAGES:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], raw_in[g]};
      end
      assign level_out[g] = chain[STAGES-1];
      assign rise_out[g]  = chain[STAGES-1] & ~chain[STAGES];
    end
  endgenerate

endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] frame
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame <= '0;
    else if (shift_en) frame <= {frame[WIDTH-2:0], din};
  end

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_loader_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic [FUNC_W-1:0]  func_q,
  output logic [DIV_W-1:0]   div_q,
  output logic [REF_W-1:0]   ref_q,
  output logic               func_v,
  output logic               div_v,
  output logic               ref_v,
  output logic               wr_func,
  output logic               wr_div,
  output logic               wr_ref
);

  cfg_target_e tgt;
  assign tgt     = decode_target(frame[ADDR_W-1:0]);
  assign wr_func = load && (tgt == TGT_FUNC);
  assign wr_div  = load && (tgt == TGT_DIV);
  assign wr_ref  = load && (tgt == TGT_REF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= '0;
      func_v <= 1'b0;
    end else if (wr_func) begin
      func_q <= func_field(frame);
      func_v <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      div_v <= 1'b0;
    end else if (wr_div) begin
      div_q <= div_field(frame);
      div_v <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      ref_v <= 1'b0;
    end else if (wr_ref) begin
      ref_q <= ref_field(frame);
      ref_v <= 1'b1;
    end
  end

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load,
  output logic [FUNC_W-1:0] func_word,
  output logic [DIV_W-1:0]  div_word,
  output logic [REF_W-1:0]  ref_word,
  output logic              func_valid,
  output logic              div_valid,
  output logic              ref_valid
);

  localparam int LN_DATA = 0;
  localparam int LN_CLK  = 1;
  localparam int LN_LOAD = 2;
  localparam int LANES   = 3;

  logic [LANES-1:0]   lvl;
  logic [LANES-1:0]   rise;
  logic               shift_pulse;
  logic               load_pulse;
  logic               data_bit;
  logic [FRAME_W-1:0] frame;
  logic               wr_func, wr_div, wr_ref;

  cfg_in_sync #(.STAGES(SYNC_STAGES), .LANES(LANES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   ({ser_load, ser_clk, ser_data}),
    .level_out(lvl),
    .rise_out (rise)
  );

  assign shift_pulse = rise[LN_CLK];
  assign load_pulse  = rise[LN_LOAD];
  assign data_bit    = lvl[LN_DATA];

  cfg_shift #(.WIDTH(FRAME_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_pulse),
    .din     (data_bit),
    .frame   (frame)
  );

  cfg_bank u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_pulse),
    .frame  (frame),
    .func_q (func_word),
    .div_q  (div_word),
    .ref_q  (ref_word),
    .func_v (func_valid),
    .div_v  (div_valid),
    .ref_v  (ref_valid),
    .wr_func(wr_func),
    .wr_div (wr_div),
    .wr_ref (wr_ref)
  );

endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk
  import cfg_loader_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               load_pulse,
  input logic               shift_pulse,
  input logic               data_bit,
  input logic [FRAME_W-1:0] frame,
  input logic [FUNC_W-1:0]  func_word,
  input logic [DIV_W-1:0]   div_word,
  input logic [REF_W-1:0]   ref_word,
  input logic               func_valid,
  input logic               div_valid,
  input logic               ref_valid
);

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> frame[0] == $past(data_bit) && frame[FRAME_W-1:1] == $past(frame[FRAME_W-2:0])); // R1

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |=> $stable(func_word) && $stable(div_word) && $stable(ref_word)); // R2

  AST_DIV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && frame[1:0] == 2'b00) |=> div_word == $past(frame[13:2]) && $stable(func_word) && $stable(ref_word)); // R3

  AST_REF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && frame[1:0] == 2'b10) |=> ref_word == $past(frame[7:2]) && $stable(func_word) && $stable(div_word)); // R4

  AST_FUNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && frame[0]) |=> func_word == $past(frame[19:2]) && $stable(div_word) && $stable(ref_word)); // R5

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(func_valid) && !$fell(div_valid) && !$fell(ref_valid)); // R7

  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(func_valid) || $rose(div_valid) || $rose(ref_valid)) |-> $past(load_pulse)); // R7

endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_pulse (load_pulse),
  .shift_pulse(shift_pulse),
  .data_bit   (data_bit),
  .frame      (frame),
  .func_word  (func_word),
  .div_word   (div_word),
  .ref_word   (ref_word),
  .func_valid (func_valid),
  .div_valid  (div_valid),
  .ref_valid  (ref_valid)
);

// File: tb/serial_cfg_loader_test.sv
module serial_cfg_loader_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, sdata = 1'b0, sload = 1'b0;
  logic [17:0] func_word;
  logic [11:0] div_word;
  logic [5:0]  ref_word;
  logic        func_valid, div_valid, ref_valid;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_loader uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_data(sdata), .ser_load(sload),
    .func_word(func_word), .div_word(div_word), .ref_word(ref_word),
    .func_valid(func_valid), .div_valid(div_valid), .ref_valid(ref_valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural model: input histories delayed by whole cycles, frame as a bit list.
  bit        hist_clk[$], hist_load[$], hist_dat[$];
  bit        m_bits[$];
  logic [17:0] m_func;
  logic [11:0] m_div;
  logic [5:0]  m_ref;
  bit        m_fv, m_dv, m_rv;

  function automatic logic [19:0] model_frame();
    logic [19:0] f = '0;
    for (int i = 0; i < 20; i++) f[i] = m_bits[i];
    return f;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist_clk = '{0, 0, 0}; hist_load = '{0, 0, 0}; hist_dat = '{0, 0, 0};
      m_bits.delete();
      for (int i = 0; i < 20; i++) m_bits.push_back(1'b0);
      m_func = '0; m_div = '0; m_ref = '0;
      m_fv = 0; m_dv = 0; m_rv = 0;
    end else begin
      logic [19:0] f;
      f = model_frame();
      // hist[k] = raw value seen k+1 edges ago
      if (hist_load[1] && !hist_load[2]) begin
        casez (f[1:0])
          2'b?1: begin m_func = f >> 2; m_fv = 1; end
          2'b10: begin m_ref = f[7:2]; m_rv = 1; end
          default: begin m_div = f[13:2]; m_dv = 1; end
        endcase
      end
      if (hist_clk[1] && !hist_clk[2]) begin
        m_bits.push_front(hist_dat[1]);
        void'(m_bits.pop_back());
      end
      hist_clk.push_front(sclk);   void'(hist_clk.pop_back());
      hist_load.push_front(sload); void'(hist_load.pop_back());
      hist_dat.push_front(sdata);  void'(hist_dat.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(func_word == m_func, "R5", "model func_word", 32'(func_word), 32'(m_func));
      chk(div_word == m_div, "R3", "model div_word", 32'(div_word), 32'(m_div));
      chk(ref_word == m_ref, "R4", "model ref_word", 32'(ref_word), 32'(m_ref));
      chk({func_valid, div_valid, ref_valid} == {m_fv, m_dv, m_rv}, "R7", "model valid flags",
          32'({func_valid, div_valid, ref_valid}), 32'({m_fv, m_dv, m_rv}));
    end
  end

  task automatic send_bit(input bit b);
    @(negedge clk) sdata = b;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_load();
    @(negedge clk) sload = 1'b1;
    repeat (4) @(negedge clk);
    sload = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  logic [19:0] fr, fr_hold, fr_short;
  logic [17:0] f_prev;

  initial begin
    repeat (5) @(negedge clk);
    // R7 reset state
    chk(func_word == 0 && div_word == 0 && ref_word == 0, "R7", "regs after reset",
        32'({func_word, div_word, ref_word}), 32'h0);
    chk({func_valid, div_valid, ref_valid} == 3'b000, "R7", "valid after reset",
        32'({func_valid, div_valid, ref_valid}), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 divider word, junk in ignored top bits; R1 MSB first
    fr = {6'b110011, 6'd45, 6'd19, 2'b00};
    send_frame(32'(fr), 20);
    pulse_load();
    chk(div_word == {6'd45, 6'd19}, "R3", "div word", 32'(div_word), 32'({6'd45, 6'd19}));
    chk(div_word[5:0] == 6'd19, "R3", "swallow count", 32'(div_word[5:0]), 32'd19);
    chk(div_word[11:6] == 6'd45, "R1", "main count order", 32'(div_word[11:6]), 32'd45);
    chk(func_word == 0 && ref_word == 0, "R6", "others after div", 32'({func_word, ref_word}), 32'h0);
    chk({func_valid, div_valid, ref_valid} == 3'b010, "R7", "valid after div",
        32'({func_valid, div_valid, ref_valid}), 32'b010);

    // R4 reference word
    fr = {12'hABC, 6'd37, 2'b10};
    send_frame(32'(fr), 20);
    pulse_load();
    chk(ref_word == 6'd37, "R4", "ref word", 32'(ref_word), 32'd37);
    chk(div_word == {6'd45, 6'd19}, "R6", "div kept after ref", 32'(div_word), 32'({6'd45, 6'd19}));

    // R5 function word, both address codes
    fr = {18'h2A5C3, 2'b01};
    send_frame(32'(fr), 20);
    pulse_load();
    chk(func_word == 18'h2A5C3, "R5", "func via 01", 32'(func_word), 32'h2A5C3);
    fr = {18'h15A3C, 2'b11};
    send_frame(32'(fr), 20);
    pulse_load();
    chk(func_word == 18'h15A3C, "R5", "func via 11", 32'(func_word), 32'h15A3C);
    chk(ref_word == 6'd37, "R6", "ref kept after func", 32'(ref_word), 32'd37);
    chk({func_valid, div_valid, ref_valid} == 3'b111, "R7", "all valid",
        32'({func_valid, div_valid, ref_valid}), 32'b111);

    // R2 shift without load changes nothing
    fr_hold = {6'h3F, 12'h5A5, 2'b00};
    send_frame(32'(fr_hold), 20);
    repeat (6) @(negedge clk);
    chk(div_word == {6'd45, 6'd19} && func_word == 18'h15A3C && ref_word == 6'd37, "R2",
        "no load hold", 32'(div_word), 32'({6'd45, 6'd19}));

    // R8 short frame of 8 bits
    fr_short = {fr_hold[11:0], 8'h9C};
    send_frame(32'h9C, 8);
    pulse_load();
    chk(div_word == fr_short[13:2], "R8", "short frame div", 32'(div_word), 32'(fr_short[13:2]));
    chk(func_word == 18'h15A3C, "R6", "func kept after short", 32'(func_word), 32'h15A3C);

    // R10 long frame, first four bits drop off
    send_frame({8'h0, 4'hE, 12'h321, 6'd50, 2'b10}, 24);
    pulse_load();
    chk(ref_word == 6'd50, "R10", "long frame ref", 32'(ref_word), 32'd50);

    // R9 latency: changes on third clk edge after strobe rises
    f_prev = func_word;
    send_frame({12'h0, 18'h0F0F1, 2'b01}, 20);
    @(negedge clk) sload = 1'b1;
    @(negedge clk);
    chk(func_word == f_prev, "R9", "one edge after strobe", 32'(func_word), 32'(f_prev));
    @(negedge clk);
    chk(func_word == f_prev, "R9", "two edges after strobe", 32'(func_word), 32'(f_prev));
    @(negedge clk);
    chk(func_word == 18'h0F0F1, "R9", "three edges after strobe", 32'(func_word), 32'h0F0F1);
    sload = 1'b0;
    repeat (6) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule